// File: doc/BRIEF.md
# Per-Destination Traffic Demand Counters

This block sits beside a node's packet switch and totals the bytes the node moves during a reporting interval. Each observed frame is presented as a single-cycle event that carries a destination node index, a byte length, a receive/transmit flag and an external/internal flag. Transmitted in-rack traffic is added to a per-destination total. Traffic that leaves the rack and traffic that enters it each go to a separate total.

A controller-side agent pulses a snapshot request at the end of each interval. In that same cycle the live totals become a frozen snapshot and the live set restarts from zero. The snapshot is then read one entry at a time over an indexed read port, while the next interval keeps counting into the other bank.

Top module: `demand_tally`

## Requirements
- R1: After reset every readable entry returns 0, and `snap_sat` and `overrun` are both 0.
- R2: An event with `ev_ext`=0 and `ev_rx`=0 adds `ev_len` to the total at index `ev_dest` (0 to NODES-1).
- R3: An event with `ev_ext`=1 adds `ev_len` to the outbound total at index NODES when `ev_rx`=0, and to the inbound total at index NODES+1 when `ev_rx`=1.
- R4: An event with `ev_ext`=0 and `ev_rx`=1 (in-rack receive) changes no total.
- R5: A `snap_req` cycle freezes all totals of the ending interval into the snapshot and restarts the live totals at zero. An event presented in the request cycle counts toward the new interval. An event presented in the cycle before counts toward the old one.
- R6: Events to the same index on consecutive cycles are all accumulated, with no update lost.
- R7: A total whose sum would exceed 2^CNT_W-1 stays at 2^CNT_W-1. `snap_sat` is 1 for a snapshot in whose interval any total saturated, and 0 otherwise.
- R8: `rd_data` shows the snapshot entry at `rd_idx` in the cycle after `rd_en`. Reads are valid from the cycle after `snap_req`. An index above NODES+1 returns 0. `rd_data` holds its value while `rd_en` is 0.
- R9: After a `snap_req`, `overrun` is 1 if a snapshot existed whose index NODES+1 had not been read since it was taken, and 0 otherwise. The flag keeps that value until the next `snap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Frame event present this cycle |
| ev_ext | input | 1 | 1 = traffic crosses the rack boundary |
| ev_rx | input | 1 | 1 = frame received, 0 = frame transmitted |
| ev_dest | input | $clog2(NODES) | In-rack destination node |
| ev_len | input | LEN_W | Frame length in bytes |
| snap_req | input | 1 | End-of-interval snapshot and clear |
| rd_en | input | 1 | Read the snapshot entry at rd_idx |
| rd_idx | input | $clog2(NODES+2) | Snapshot entry index |
| rd_data | output | CNT_W | Snapshot entry read one cycle earlier |
| snap_sat | output | 1 | Some total of the current snapshot saturated |
| overrun | output | 1 | Current snapshot replaced an undrained one |

## Verification
On every cycle the assertions check the following: a bank that was just cleared reads as empty with its saturation flag low, back-to-back writes to one entry never go backwards, every request swaps the banks, the overrun flag follows the drain state, and the read port returns zero out of range and holds when idle. Only the bench scenarios can show the byte totals themselves. These include the placement of an event that coincides with a request, the clamped value of a saturated total, the dropped in-rack receive, and the summing of bursts to one entry, compared entry by entry against a reference model.

// File: rtl/dtally_pkg.sv
// Shared types for the demand tally block.
// Assumes: nothing beyond standard SystemVerilog.
package dtally_pkg;

    typedef enum logic [1:0] {
        EV_DROP,
        EV_LOCAL,
        EV_EXT_OUT,
        EV_EXT_IN
    } ev_kind_e;

    // Classify an event by its boundary and direction flags.
    function automatic ev_kind_e classify(logic ext, logic rx);
        if (ext) begin
            return rx ? EV_EXT_IN : EV_EXT_OUT;
        end
        return rx ? EV_DROP : EV_LOCAL;
    endfunction

endpackage

// File: rtl/dtally_route.sv
// Maps a frame event to the counter entry it updates.
// Assumes: NODES >= 2; entries NODES and NODES+1 hold outbound and inbound totals.
module dtally_route
    import dtally_pkg::*;
#(
    parameter int NODES = 8,
    localparam int ENTRIES = NODES + 2,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int DST_W = $clog2(NODES)
) (
    input  logic             ev_valid,
    input  logic             ev_ext,
    input  logic             ev_rx,
    input  logic [DST_W-1:0] ev_dest,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    ev_kind_e kind;

    // Decode the event class into a target entry and a hit strobe.
    always_comb begin
        kind = classify(ev_ext, ev_rx);
        hit  = 1'b0;
        idx  = '0;
        case (kind)
            EV_LOCAL: begin
                hit = ev_valid && (32'(ev_dest) < NODES);
                idx = IDX_W'(ev_dest);
            end
            EV_EXT_OUT: begin
                hit = ev_valid;
                idx = IDX_W'(NODES);
            end
            EV_EXT_IN: begin
                hit = ev_valid;
                idx = IDX_W'(NODES + 1);
            end
            default: begin
                hit = 1'b0;
                idx = '0;
            end
        endcase
    end

endmodule

// File: rtl/dtally_bank.sv
// One bank of byte totals: a register array with one write port and two
// read ports, a per-entry written mask giving a one-cycle bulk clear, and a
// sticky saturation flag.
// Assumes: clr and wr_en never target this bank in the same cycle.
module dtally_bank #(
    parameter int ENTRIES = 10,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             wr_sat,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [CNT_W-1:0] ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [CNT_W-1:0] rb_data,
    output logic             sat
);

    logic [CNT_W-1:0]   mem [ENTRIES];
    logic [ENTRIES-1:0] used_q;
    logic               sat_q;

    // Store the accumulated value; contents are qualified by used_q.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_val;
        end
    end

    // Track which entries hold data of the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            used_q <= '0;
        end else if (wr_en) begin
            used_q[wr_idx] <= 1'b1;
        end
    end

    // Sticky saturation flag for this bank's interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sat_q <= 1'b0;
        end else if (wr_en && wr_sat) begin
            sat_q <= 1'b1;
        end
    end

    // Read ports return zero for unwritten or out-of-range entries.
    always_comb begin
        ra_data = '0;
        rb_data = '0;
        if (32'(ra_idx) < ENTRIES && used_q[ra_idx]) begin
            ra_data = mem[ra_idx];
        end
        if (32'(rb_idx) < ENTRIES && used_q[rb_idx]) begin
            rb_data = mem[rb_idx];
        end
    end

    assign sat = sat_q;

    // R5: a bank read in the cycle after its clear is empty.
    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (ra_data == '0 && rb_data == '0 && !sat));

endmodule

// File: rtl/dtally_accum.sv
// Two-stage read-modify-write accumulator with last-write forwarding and
// saturating addition.
// Assumes: in_base is the target bank's entry at in_idx in the capture cycle;
// in_fresh marks a bank being cleared on that same edge.
module dtally_accum #(
    parameter int IDX_W = 4,
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_hit,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [LEN_W-1:0] in_len,
    input  logic             in_bank,
    input  logic             in_fresh,
    input  logic [CNT_W-1:0] in_base,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] wr_val,
    output logic             wr_sat
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             s1_vld, lw_vld;
    logic [IDX_W-1:0] s1_idx, lw_idx;
    logic [LEN_W-1:0] s1_len;
    logic             s1_bank, lw_bank;
    logic [CNT_W-1:0] s1_base, lw_val;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;
    logic             fwd;

    // Stage 1 valid: capture the event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= in_hit;
        end
    end

    // Stage 1 data: capture target, length and the registered base read.
    always_ff @(posedge clk) begin
        s1_idx  <= in_idx;
        s1_len  <= in_len;
        s1_bank <= in_bank;
        s1_base <= in_fresh ? '0 : in_base;
    end

    // Substitute the value written last cycle when it targets the same entry.
    always_comb begin
        fwd    = lw_vld && (lw_idx == s1_idx) && (lw_bank == s1_bank);
        base   = fwd ? lw_val : s1_base;
        sum    = {1'b0, base} + (CNT_W + 1)'(s1_len);
        wr_sat = sum[CNT_W];
        wr_val = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    assign wr_en   = s1_vld;
    assign wr_bank = s1_bank;
    assign wr_idx  = s1_idx;

    // Last-write register used for forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_vld <= 1'b0;
        end else begin
            lw_vld <= s1_vld;
        end
        lw_idx  <= s1_idx;
        lw_bank <= s1_bank;
        lw_val  <= wr_val;
    end

    // R6: consecutive writes to one entry of one bank never decrease it.
    p_chain_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && wr_idx == $past(wr_idx) && wr_bank == $past(wr_bank))
        |-> (wr_val >= $past(wr_val)));

    // R7: a saturating write carries the ceiling value.
    p_clamp_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sat) |-> (wr_val == CNT_MAX && base != '0));

endmodule

// File: rtl/demand_tally.sv
// Per-destination byte demand counters with atomic snapshot and clear.
// Two banks alternate between live counting and frozen snapshot; a request
// swaps them and bulk-clears the new live bank in one cycle.
// Assumes: NODES >= 2, LEN_W <= CNT_W; one event per cycle at most.
module demand_tally #(
    parameter int NODES = 8,
    parameter int CNT_W = 16,
    parameter int LEN_W = 12,
    localparam int ENTRIES = NODES + 2,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int DST_W = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_ext,
    input  logic             ev_rx,
    input  logic [DST_W-1:0] ev_dest,
    input  logic [LEN_W-1:0] ev_len,
    input  logic             snap_req,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_data,
    output logic             snap_sat,
    output logic             overrun
);

    logic             live_q, new_live, snap_bank;
    logic             ev_hit;
    logic [IDX_W-1:0] ev_idx;
    logic [CNT_W-1:0] bank_ra [2];
    logic [CNT_W-1:0] bank_rb [2];
    logic [1:0]       bank_sat;
    logic             acc_wr_en, acc_wr_bank, acc_wr_sat;
    logic [IDX_W-1:0] acc_wr_idx;
    logic [CNT_W-1:0] acc_wr_val;
    logic             have_q, drained_q, overrun_q;

    assign new_live  = snap_req ? ~live_q : live_q;
    assign snap_bank = ~live_q;

    dtally_route #(.NODES(NODES)) u_route (
        .ev_valid (ev_valid),
        .ev_ext   (ev_ext),
        .ev_rx    (ev_rx),
        .ev_dest  (ev_dest),
        .hit      (ev_hit),
        .idx      (ev_idx)
    );

    dtally_accum #(.IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_hit   (ev_hit),
        .in_idx   (ev_idx),
        .in_len   (ev_len),
        .in_bank  (new_live),
        .in_fresh (snap_req),
        .in_base  (bank_ra[new_live]),
        .wr_en    (acc_wr_en),
        .wr_bank  (acc_wr_bank),
        .wr_idx   (acc_wr_idx),
        .wr_val   (acc_wr_val),
        .wr_sat   (acc_wr_sat)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        dtally_bank #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (snap_req && (live_q != 1'(b))),
            .wr_en   (acc_wr_en && (acc_wr_bank == 1'(b))),
            .wr_idx  (acc_wr_idx),
            .wr_val  (acc_wr_val),
            .wr_sat  (acc_wr_sat),
            .ra_idx  (ev_idx),
            .ra_data (bank_ra[b]),
            .rb_idx  (rd_idx),
            .rb_data (bank_rb[b]),
            .sat     (bank_sat[b])
        );
    end

    // Bank roles: swap on every snapshot request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else if (snap_req) begin
            live_q <= ~live_q;
        end
    end

    // Readout register: one-cycle latency, holds while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= bank_rb[snap_bank];
        end
    end

    // Drain tracking and overrun flag for the snapshot in the readout bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q    <= 1'b0;
            drained_q <= 1'b0;
            overrun_q <= 1'b0;
        end else if (snap_req) begin
            overrun_q <= have_q && !drained_q;
            have_q    <= 1'b1;
            drained_q <= 1'b0;
        end else if (rd_en && rd_idx == IDX_W'(ENTRIES - 1)) begin
            drained_q <= 1'b1;
        end
    end

    assign overrun  = overrun_q;
    assign snap_sat = bank_sat[snap_bank];

    // R5: each request hands the live role to the other bank.
    p_swap_roles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (live_q != $past(live_q)));

    // R9: an undrained snapshot being replaced raises the flag.
    p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_req && have_q && !drained_q) |=> overrun);

    // R9: a drained snapshot being replaced leaves the flag low.
    p_overrun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_req && drained_q) |=> !overrun);

    // R8: out-of-range reads return zero.
    p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && 32'(rd_idx) >= ENTRIES) |=> (rd_data == '0));

    // R8: the read register holds while no read is issued.
    p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_demand_tally.sv
module tb_demand_tally;

    localparam int NODES   = 8;
    localparam int CNT_W   = 16;
    localparam int LEN_W   = 12;
    localparam int ENTRIES = NODES + 2;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int DST_W   = $clog2(NODES);
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ev_valid, ev_ext, ev_rx, snap_req, rd_en;
    logic [DST_W-1:0] ev_dest;
    logic [LEN_W-1:0] ev_len;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] rd_data;
    logic             snap_sat, overrun;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    int    exp_live [ENTRIES];
    int    exp_snap [ENTRIES];
    bit    sat_live, sat_snap;
    int    q_val [$];
    string q_tag [$];
    logic  pend = 1'b0;
    int    last_read;

    always #4 clk = ~clk;

    demand_tally #(.NODES(NODES), .CNT_W(CNT_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ext(ev_ext),
        .ev_rx(ev_rx), .ev_dest(ev_dest), .ev_len(ev_len),
        .snap_req(snap_req), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .snap_sat(snap_sat), .overrun(overrun)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard for each read captured at the last edge.
    always @(posedge clk) pend <= rd_en;
    always @(negedge clk) begin
        if (pend && rst_n) begin
            if (q_val.size() == 0) begin
                check("scoreboard underflow", int'(rd_data), -1);
            end else begin
                check(q_tag.pop_front(), int'(rd_data), q_val.pop_front());
            end
        end
    end

    function automatic void model_add(bit ext, bit rx, int dest, int len);
        int idx;
        int s;
        if (!ext && rx) return;
        idx = ext ? (rx ? NODES + 1 : NODES) : dest;
        s = exp_live[idx] + len;
        if (s > CMAX) begin
            s = CMAX;
            sat_live = 1'b1;
        end
        exp_live[idx] = s;
    endfunction

    task automatic quiet();
        ev_valid = 1'b0;
        snap_req = 1'b0;
        rd_en    = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        quiet();
        repeat (n) step();
    endtask

    task automatic send(bit ext, bit rx, int dest, int len);
        quiet();
        ev_valid = 1'b1;
        ev_ext   = ext;
        ev_rx    = rx;
        ev_dest  = DST_W'(dest);
        ev_len   = LEN_W'(len);
        model_add(ext, rx, dest, len);
        step();
    endtask

    task automatic snap(bit with_ev, int dest, int len);
        quiet();
        snap_req = 1'b1;
        exp_snap = exp_live;
        sat_snap = sat_live;
        foreach (exp_live[i]) exp_live[i] = 0;
        sat_live = 1'b0;
        if (with_ev) begin
            ev_valid = 1'b1;
            ev_ext   = 1'b0;
            ev_rx    = 1'b0;
            ev_dest  = DST_W'(dest);
            ev_len   = LEN_W'(len);
            model_add(1'b0, 1'b0, dest, len);
        end
        step();
    endtask

    task automatic read(int i, string tag);
        quiet();
        rd_en  = 1'b1;
        rd_idx = IDX_W'(i);
        last_read = (i < ENTRIES) ? exp_snap[i] : 0;
        q_val.push_back(last_read);
        q_tag.push_back($sformatf("%s entry %0d", tag, i));
        step();
    endtask

    task automatic read_upto(int top, string tag);
        for (int i = 0; i <= top; i++) read(i, tag);
        idle(2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        foreach (exp_live[i]) begin
            exp_live[i] = 0;
            exp_snap[i] = 0;
        end
        sat_live = 1'b0;
        sat_snap = 1'b0;
        quiet();
        ev_ext = 1'b0; ev_rx = 1'b0; ev_dest = '0; ev_len = '0; rd_idx = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();

        // R1: reset state.
        check("R1 overrun", int'(overrun), 0);
        check("R1 snap_sat", int'(snap_sat), 0);
        check("R1 rd_data", int'(rd_data), 0);
        read_upto(ENTRIES - 1, "R1 reset read");

        // Interval 1: local, external and ignored traffic.
        send(0, 0, 0, 100);             // R2
        send(0, 0, 3, 200);             // R2
        idle(1);
        send(0, 0, 3, 50);              // R2
        send(1, 0, 0, 1000);            // R3 outbound
        send(1, 1, 4, 700);             // R3 inbound
        send(0, 1, 1, 100);             // R4 ignored
        idle(2);
        snap(1, 5, 33);                 // R5: this event belongs to interval 2
        idle(1);
        check("R9 first snapshot overrun", int'(overrun), 0);
        check("R7 clean snap_sat", int'(snap_sat), 0);
        read_upto(ENTRIES - 1, "R2 R3 R4 R5 interval1");

        // Hold and out-of-range reads.
        idle(3);
        check("R8 hold", int'(rd_data), last_read);
        read(12, "R8 out of range");
        idle(2);

        // Interval 2: burst to one entry and an event just before the request.
        for (int k = 1; k <= 5; k++) send(0, 0, 7, k);   // R6
        send(0, 0, 2, 7);
        send(0, 0, 7, 20);              // R6 after a gap of one other event
        send(0, 0, 6, 9);               // R5: cycle before request, old interval
        snap(0, 0, 0);
        idle(1);
        check("R9 drained snapshot overrun", int'(overrun), 0);
        read_upto(NODES, "R5 R6 interval2");   // index NODES+1 not read

        // Interval 3: saturation, replacing an undrained snapshot.
        for (int k = 0; k < 17; k++) send(0, 0, 2, 4095);  // R7
        send(1, 1, 0, 5);
        idle(1);
        snap(0, 0, 0);
        idle(1);
        check("R9 undrained overrun", int'(overrun), 1);
        check("R7 saturated snap_sat", int'(snap_sat), 1);
        read_upto(ENTRIES - 1, "R7 interval3");

        // Interval 4: drained predecessor, no saturation.
        send(1, 0, 0, 77);
        snap(0, 0, 0);
        idle(1);
        check("R9 overrun cleared", int'(overrun), 0);
        check("R7 snap_sat cleared", int'(snap_sat), 0);
        read_upto(ENTRIES - 1, "R3 interval4");
        idle(2);
        check("scoreboard drained", q_val.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule